// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is the general-purpose register file of a single-cycle 32-bit integer datapath. It holds 32 entries of 32 bits. Two read ports, each with its own 5-bit address, return operand data combinationally, with no clock involved. One write port commits a 32-bit value on the falling edge of a dedicated write clock, so a write issued early in a cycle lands in the middle of that cycle. The result is then visible to the next instruction's combinational reads.

Entry 0 is a constant zero. A write that targets it is dropped in the write decoder and never stored. The other entries have no reset and start undefined, so software or the bench initialises them through writes. The active-low reset only holds off writes while it is asserted. It leaves the stored contents alone.

Top module: `regfile_2r1w`

## Requirements
- R1: Each of the 31 writable entries (addresses 1 to 31) stores a 32-bit value written to it, and either read port returns that value when given the same address.
- R2: While `wr_en_i` is 0, a falling edge of `wclk_i` changes no entry, whatever `wr_addr_i` and `wr_data_i` hold.
- R3: Read data is a combinational function of the read address and the stored contents. Changing a read address changes the data output with no clock edge in between.
- R4: A write commits on the falling edge of `wclk_i`. A read of the address being written shows the old contents before that edge and the new contents after it.
- R5: Address 0 reads as 32'h0000_0000 on both read ports at all times, including during reset.
- R6: A write to address 0 is discarded, so later reads of address 0 still return zero.
- R7: While `rst_ni` is 0, writes are blocked. Asserting `rst_ni` low does not clear the stored entries.
- R8: The two read ports are independent. A write to one address leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock; writes commit on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset; blocks writes while low |
| wr_en_i | input | 1 | Active-high write enable |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_a_addr_i | input | 5 | Read port A address |
| rd_a_data_o | output | 32 | Read port A data (combinational) |
| rd_b_addr_i | input | 5 | Read port B address |
| rd_b_data_o | output | 32 | Read port B data (combinational) |

## Verification
The bench goes after the half-cycle write window. It samples a read of the address being written both before and after the falling edge. A design that writes on the rising edge would show the new value too early, and one that registers its reads would lag by a cycle. It writes all ones to address 0 and expects zero on both ports, which catches a design that stores entry 0. It toggles write data and address with the enable low, asserts reset during a write attempt, and checks neighbouring entries after a write. These catch a missing enable gate, a reset that clears or fails to block, and an address decoder that aliases entries.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  parameter int unsigned RF_DEPTH = 32;
  parameter int unsigned RF_WIDTH = 32;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned AW    = 5
) (
  input  logic             en_i,
  input  logic [AW-1:0]    addr_i,
  output logic [NREGS-1:1] strobe_o
);
  // entry 0 gets no strobe, so a write to it is dropped here
  for (genvar i = 1; i < NREGS; i++) begin : g_strobe
    assign strobe_o[i] = en_i && (addr_i == AW'(i));
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned DW    = 32
) (
  input  logic                      clk_i,
  input  logic [NREGS-1:1]          strobe_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [NREGS-1:0][DW-1:0]  rows_o
);
  for (genvar i = 0; i < NREGS; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign rows_o[i] = '0;
    end else begin : g_flop
      logic [DW-1:0] ent_q;
      always_ff @(negedge clk_i) begin
        if (strobe_i[i]) ent_q <= wdata_i;
      end
      assign rows_o[i] = ent_q;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 5
) (
  input  logic [NREGS-1:0][DW-1:0] rows_i,
  input  logic [AW-1:0]            addr_i,
  output logic [DW-1:0]            data_o
);
  if (NREGS == (1 << AW)) begin : g_full
    assign data_o = rows_i[addr_i];
  end else begin : g_part
    // addresses past the last entry return zero
    always_comb begin
      data_o = '0;
      if (int'(addr_i) < int'(NREGS)) data_o = rows_i[addr_i];
    end
  end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int unsigned NREGS = regfile_pkg::RF_DEPTH,
  parameter int unsigned DW    = regfile_pkg::RF_WIDTH
) (
  input  logic                     wclk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [$clog2(NREGS)-1:0] wr_addr_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic [$clog2(NREGS)-1:0] rd_a_addr_i,
  output logic [DW-1:0]            rd_a_data_o,
  input  logic [$clog2(NREGS)-1:0] rd_b_addr_i,
  output logic [DW-1:0]            rd_b_data_o
);
  localparam int unsigned AW = $clog2(NREGS);

  logic [NREGS-1:1]         strobe;
  logic [NREGS-1:0][DW-1:0] rows;
  logic                     wr_go;

  assign wr_go = wr_en_i && rst_ni;

  rf_wr_decode #(.NREGS(NREGS), .AW(AW)) u_dec (
    .en_i     (wr_go),
    .addr_i   (wr_addr_i),
    .strobe_o (strobe)
  );

  rf_bank #(.NREGS(NREGS), .DW(DW)) u_bank (
    .clk_i    (wclk_i),
    .strobe_i (strobe),
    .wdata_i  (wr_data_i),
    .rows_o   (rows)
  );

  rf_read_port #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_rd_a (
    .rows_i (rows),
    .addr_i (rd_a_addr_i),
    .data_o (rd_a_data_o)
  );

  rf_read_port #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_rd_b (
    .rows_i (rows),
    .addr_i (rd_b_addr_i),
    .data_o (rd_b_data_o)
  );
endmodule

// File: rtl/regfile_2r1w_chk.sv
module regfile_2r1w_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input logic          wclk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic [AW-1:0] rd_a_addr_i,
  input logic [DW-1:0] rd_a_data_o,
  input logic [AW-1:0] rd_b_addr_i,
  input logic [DW-1:0] rd_b_data_o
);
  logic          sh_vld;
  logic [AW-1:0] sh_addr;
  logic [DW-1:0] sh_data;

  // remembers the most recent accepted write
  always_ff @(negedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) sh_vld <= 1'b0;
    else if (wr_en_i && wr_addr_i != '0) sh_vld <= 1'b1;
  end

  always_ff @(negedge wclk_i) begin
    if (rst_ni && wr_en_i && wr_addr_i != '0) begin
      sh_addr <= wr_addr_i;
      sh_data <= wr_data_i;
    end
  end

  assert_zero_port_a_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (rd_a_addr_i == '0) |-> (rd_a_data_o == '0));

  assert_zero_port_b_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (rd_b_addr_i == '0) |-> (rd_b_data_o == '0));

  assert_last_write_a_R4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (sh_vld && rd_a_addr_i == sh_addr) |-> (rd_a_data_o == sh_data));

  assert_last_write_b_R4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (sh_vld && rd_b_addr_i == sh_addr) |-> (rd_b_data_o == sh_data));
endmodule

bind regfile_2r1w regfile_2r1w_chk #(.AW(AW), .DW(DW)) u_chk (
  .wclk_i      (wclk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .rd_a_addr_i (rd_a_addr_i),
  .rd_a_data_o (rd_a_data_o),
  .rd_b_addr_i (rd_b_addr_i),
  .rd_b_data_o (rd_b_data_o)
);

// File: tb/regfile_2r1w_test.sv
module regfile_2r1w_test;
  localparam int N = 32;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [4:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic [4:0]   ra, rb;
  logic [W-1:0] da, db;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] model [N];

  always #5 clk = ~clk;

  regfile_2r1w uut (
    .wclk_i      (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_a_addr_i (ra),
    .rd_a_data_o (da),
    .rd_b_addr_i (rb),
    .rd_b_data_o (db)
  );

  function automatic logic [W-1:0] pattern(int i);
    return 32'h5A3C_9600 ^ (32'(i) * 32'h0101_0101);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [4:0] a, logic [W-1:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
    if (rst_n && a != 5'd0) model[a] = d;
  endtask

  task automatic peek(logic [4:0] a, logic [4:0] b);
    ra = a; rb = b; #1;
  endtask

  task automatic t_reset_zero;
    peek(5'd0, 5'd0);
    check("R5 port A in reset", da, '0);
    check("R5 port B in reset", db, '0);
  endtask

  task automatic t_fill_readback;
    for (int i = 1; i < N; i++) write_reg(5'(i), pattern(i));
    for (int i = 0; i < N; i++) begin
      peek(5'(i), 5'(N - 1 - i));
      check("R1 port A readback", da, model[i]);
      check("R1 port B readback", db, model[N - 1 - i]);
    end
  endtask

  task automatic t_async_read;
    @(posedge clk); #1;
    peek(5'd3, 5'd4);
    check("R3 port A first addr", da, model[3]);
    check("R3 port B first addr", db, model[4]);
    peek(5'd12, 5'd20);
    check("R3 port A changed addr", da, model[12]);
    check("R3 port B changed addr", db, model[20]);
  endtask

  task automatic t_enable_low;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_addr = 5'd6; wr_data = 32'hFFFF_0000;
    @(negedge clk); #1;
    peek(5'd6, 5'd6);
    check("R2 port A no write", da, model[6]);
    check("R2 port B no write", db, model[6]);
  endtask

  task automatic t_fall_edge;
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 5'd14; wr_data = 32'hC0FF_EE11;
    ra = 5'd14; rb = 5'd14;
    #2;
    check("R4 old value before fall", da, model[14]);
    @(negedge clk); #1;
    model[14] = 32'hC0FF_EE11;
    wr_en = 1'b0;
    check("R4 port A new after fall", da, model[14]);
    check("R4 port B new after fall", db, model[14]);
  endtask

  task automatic t_zero_write;
    write_reg(5'd0, 32'hFFFF_FFFF);
    peek(5'd0, 5'd0);
    check("R6 port A after write", da, '0);
    check("R6 port B after write", db, '0);
    write_reg(5'd1, 32'h0000_0001);
    peek(5'd0, 5'd1);
    check("R6 zero stays", da, '0);
    check("R1 entry 1", db, 32'h0000_0001);
  endtask

  task automatic t_isolation;
    write_reg(5'd9, 32'h1234_5678);
    peek(5'd8, 5'd10);
    check("R8 neighbour below", da, model[8]);
    check("R8 neighbour above", db, model[10]);
    peek(5'd9, 5'd25);
    check("R8 written entry", da, 32'h1234_5678);
    check("R8 far entry", db, model[25]);
  endtask

  task automatic t_reset_hold;
    @(posedge clk); #1;
    rst_n = 1'b0;
    write_reg(5'd7, 32'hDEAD_BEEF);
    peek(5'd0, 5'd7);
    check("R5 port A zero in reset", da, '0);
    check("R7 blocked in reset", db, model[7]);
    @(posedge clk); #1;
    rst_n = 1'b1;
    peek(5'd7, 5'd30);
    check("R7 kept after reset", da, model[7]);
    check("R7 other kept", db, model[30]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ra = '0; rb = '0;
    model[0] = '0;
    #1;
    t_reset_zero();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_fill_readback();
    t_async_read();
    t_enable_low();
    t_fall_edge();
    t_zero_write();
    t_isolation();
    t_reset_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule